// File: doc/BRIEF.md
# Bitstream Window Aligner

This block sits between a word-wide store of compressed video bitstream and the syntax decoders that parse it. It keeps the two oldest unconsumed 32-bit words in a register pair and, through a combinational left barrel shifter, always presents the next 32 unconsumed bits of the stream. The first of those bits is always in the most significant position of the window.

Each decode step, one of four decoders reports how many bits it consumed: fixed-length, Exp-Golomb, table-driven variable-length, or arithmetic renormalisation. A source selector picks which report applies. The selected length is added to a 5-bit bit-position accumulator. When the sum reaches 32 or more, the carry refills the register pair with the word at the current read address. In that same cycle the block raises its load strobe and advances the read address by one.

The window is a stream output. `win_valid` is its valid signal and `adv_en` is the consumer's ready/advance. The state moves only on a cycle where both are high. While `adv_en` is low the window, position and address hold, which is the back-pressure rule. The word store must present, on `ram_rdata`, the word at `ram_addr` in the same cycle. The word for the next refill is therefore already on the bus when the address has advanced.

Top module: `bitwin_aligner`

## Requirements
- R1: After reset, `ram_addr` is 0 and `win_valid` is low. `load` stays high for exactly the first two clock cycles after reset release, which prefill both registers. From then on `win_valid` is high and stays high, and the window shows stream bits 0..31 (word 0).
- R2: While valid, `window[31]` is stream bit P and `window[0]` is stream bit P+31. P is the total number of bits consumed so far. Stream bit 0 is the MSB of word 0.
- R3: On a cycle with `adv_en` and `win_valid` high, P grows by the selected length.
- R4: On an advancing cycle where the old position (P mod 32) plus the selected length is 32 or more, `load` is high in that cycle. The register pair then shifts one word, so the window continues seamlessly across the word boundary.
- R5: `src_sel` encodes the length source: 0 selects `len_fixed`, 1 `len_expg`, 2 `len_vlc`, 3 `len_arith`. Unselected lengths have no effect on the window.
- R6: A selected length of 0 on an advancing cycle leaves the window, `ram_addr` and `load` (low) unchanged.
- R7: With `adv_en` low after prefill, `load` is low and the window and `ram_addr` do not change.
- R8: A selected length above 32 is treated as 32.
- R9: `ram_addr` advances by exactly one at each clock edge where `load` is high and holds otherwise. After prefill it equals 2 + floor(P/32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | Consumer advance/ready; the state moves only when high and the window is valid |
| src_sel | input | 2 | Length source select (0 fixed, 1 Exp-Golomb, 2 VLC, 3 arithmetic) |
| len_fixed | input | 6 | Bits consumed by the fixed-length decoder |
| len_expg | input | 6 | Bits consumed by the Exp-Golomb decoder |
| len_vlc | input | 6 | Bits consumed by the variable-length table decoder |
| len_arith | input | 6 | Bits consumed by arithmetic renormalisation |
| ram_rdata | input | 32 | Word at `ram_addr`, valid in the same cycle |
| ram_addr | output | 16 | Word read address |
| load | output | 1 | Refill strobe; the register pair takes `ram_rdata` at the next edge |
| win_valid | output | 1 | Window valid |
| window | output | 32 | Next 32 unconsumed bits, oldest bit at the MSB |

## Verification
Two functions can land in one cycle: advancing the bit position and refilling a word from the store. The window seen after that edge must then be stitched from the remainder of the old word and the start of a word that just arrived. The bench provokes this with directed steps that finish a word exactly (position plus length equal to 32), that cross a word boundary from position 31, and that consume a whole 32-bit or clamped length from a mid-word position. Random steps add many more crossings, and each one is judged against a window the bench cuts from its own model of the stream at the running consumed-bit count.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  typedef enum logic [1:0] {
    SRC_FIXED = 2'd0,
    SRC_EXPG  = 2'd1,
    SRC_VLC   = 2'd2,
    SRC_ARITH = 2'd3
  } src_e;
endpackage

// File: rtl/bwa_len_mux.sv
module bwa_len_mux #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = $clog2(WORD_W) + 1
) (
  input  bwa_pkg::src_e     sel,
  input  logic [LEN_W-1:0]  len_fixed,
  input  logic [LEN_W-1:0]  len_expg,
  input  logic [LEN_W-1:0]  len_vlc,
  input  logic [LEN_W-1:0]  len_arith,
  output logic [LEN_W-1:0]  len_o
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(WORD_W);

  logic [LEN_W-1:0] raw;

  always_comb begin
    unique case (sel)
      bwa_pkg::SRC_FIXED: raw = len_fixed;
      bwa_pkg::SRC_EXPG:  raw = len_expg;
      bwa_pkg::SRC_VLC:   raw = len_vlc;
      default:            raw = len_arith;
    endcase
    // lengths beyond one word saturate to a whole word
    len_o = (raw > MAX_LEN) ? MAX_LEN : raw;
  end
endmodule

// File: rtl/bwa_pos_acc.sv
module bwa_pos_acc #(
  parameter int WORD_W = 32,
  parameter int POS_W  = $clog2(WORD_W),
  parameter int LEN_W  = POS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [LEN_W-1:0] len,
  output logic [POS_W-1:0] pc,
  output logic             carry
);
  logic [LEN_W-1:0] sum;

  always_comb begin
    sum   = LEN_W'(pc) + len;
    carry = step && (sum[LEN_W-1:POS_W] != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pc <= '0;
    else if (step) pc <= sum[POS_W-1:0];
  end
endmodule

// File: rtl/bwa_word_pair.sv
module bwa_word_pair #(
  parameter int WORD_W = 32,
  parameter int POS_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [WORD_W-1:0] new_word,
  input  logic [POS_W-1:0]  pc,
  output logic [WORD_W-1:0] window
);
  localparam int PAIR_W = 2 * WORD_W;

  logic [WORD_W-1:0] older_q, newer_q;
  logic [PAIR_W-1:0] shifted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older_q <= '0;
      newer_q <= '0;
    end else if (shift_en) begin
      older_q <= newer_q;
      newer_q <= new_word;
    end
  end

  always_comb begin
    shifted = {older_q, newer_q} << pc;
    window  = shifted[PAIR_W-1:WORD_W];
  end
endmodule

// File: rtl/bitwin_aligner.sv
module bitwin_aligner #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16,
  parameter int POS_W  = $clog2(WORD_W),
  parameter int LEN_W  = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic [1:0]        src_sel,
  input  logic [LEN_W-1:0]  len_fixed,
  input  logic [LEN_W-1:0]  len_expg,
  input  logic [LEN_W-1:0]  len_vlc,
  input  logic [LEN_W-1:0]  len_arith,
  input  logic [WORD_W-1:0] ram_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              load,
  output logic              win_valid,
  output logic [WORD_W-1:0] window
);
  localparam int PREFILL = 2;
  localparam int FILL_W  = $clog2(PREFILL + 1);

  logic [FILL_W-1:0] fill_cnt;
  logic              filling;
  logic              step;
  logic              carry;
  logic [LEN_W-1:0]  len_sel;
  logic [POS_W-1:0]  pc;

  assign filling   = fill_cnt != FILL_W'(PREFILL);
  assign win_valid = !filling;
  assign step      = adv_en && win_valid;
  assign load      = rst_n && (filling || carry);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fill_cnt <= '0;
    else if (filling) fill_cnt <= fill_cnt + FILL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ram_addr <= '0;
    else if (load) ram_addr <= ram_addr + ADDR_W'(1);
  end

  bwa_len_mux #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_mux (
    .sel       (bwa_pkg::src_e'(src_sel)),
    .len_fixed (len_fixed),
    .len_expg  (len_expg),
    .len_vlc   (len_vlc),
    .len_arith (len_arith),
    .len_o     (len_sel)
  );

  bwa_pos_acc #(.WORD_W(WORD_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .len   (len_sel),
    .pc    (pc),
    .carry (carry)
  );

  bwa_word_pair #(.WORD_W(WORD_W), .POS_W(POS_W)) u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (load),
    .new_word (ram_rdata),
    .pc       (pc),
    .window   (window)
  );
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv_en,
  input logic              load,
  input logic              win_valid,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [WORD_W-1:0] window
);
  a_r1_prefill_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> load);

  a_r1_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |=> win_valid);

  a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ram_addr == $past(ram_addr) + ADDR_W'(1));

  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(ram_addr));

  a_r7_no_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !adv_en) |-> !load);

  a_r7_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !adv_en) |=> $stable(window));
endmodule

bind bitwin_aligner bwa_checker #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adv_en    (adv_en),
  .load      (load),
  .win_valid (win_valid),
  .ram_addr  (ram_addr),
  .window    (window)
);

// File: tb/tb_bitwin_aligner.sv
`timescale 1ns/1ps
module tb_bitwin_aligner;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_en = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic [5:0]  len_fixed = '0, len_expg = '0, len_vlc = '0, len_arith = '0;
  logic [31:0] ram_rdata;
  logic [15:0] ram_addr;
  logic        load, win_valid;
  logic [31:0] window;

  int checks = 0;
  int errors = 0;
  int consumed = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] sw(input int a);
    logic [31:0] x;
    x = 32'(a) * 32'h9E3779B9;
    return x ^ 32'h5A5AC3C3 ^ {x[15:0], x[31:16]};
  endfunction

  function automatic logic [31:0] exp_win(input int pos);
    logic [63:0] d;
    d = {sw(pos / 32), sw(pos / 32 + 1)} << (pos % 32);
    return d[63:32];
  endfunction

  function automatic int clampl(input logic [5:0] l);
    return (int'(l) > 32) ? 32 : int'(l);
  endfunction

  assign ram_rdata = sw(int'(ram_addr));

  bitwin_aligner dut (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .src_sel(src_sel),
    .len_fixed(len_fixed), .len_expg(len_expg), .len_vlc(len_vlc),
    .len_arith(len_arith), .ram_rdata(ram_rdata), .ram_addr(ram_addr),
    .load(load), .win_valid(win_valid), .window(window)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive one cycle, check load, then check the state after the edge.
  task automatic step(input logic adv, input logic [1:0] s,
                      input logic [5:0] lf, input logic [5:0] le,
                      input logic [5:0] lv, input logic [5:0] la, input string tag);
    int l;
    logic exp_load;
    adv_en = adv; src_sel = s;
    len_fixed = lf; len_expg = le; len_vlc = lv; len_arith = la;
    case (s)
      2'd0: l = clampl(lf);
      2'd1: l = clampl(le);
      2'd2: l = clampl(lv);
      default: l = clampl(la);
    endcase
    if (!adv) l = 0;
    exp_load = adv && ((consumed % 32) + l >= 32);
    #1;
    chk({tag, " R4 load"}, 64'(load), 64'(exp_load));
    @(posedge clk);
    @(negedge clk);
    consumed += l;
    chk({tag, " R2 window"}, 64'(window), 64'(exp_win(consumed)));
    chk({tag, " R9 addr"}, 64'(ram_addr), 64'(2 + consumed / 32));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 addr in reset", 64'(ram_addr), 0);
    chk("R1 valid in reset", 64'(win_valid), 0);
    rst_n = 1'b1;
    #1;
    chk("R1 load prefill0", 64'(load), 1);
    @(negedge clk); #1;
    chk("R1 load prefill1", 64'(load), 1);
    chk("R1 valid prefill1", 64'(win_valid), 0);
    @(negedge clk); #1;
    chk("R1 valid after", 64'(win_valid), 1);
    chk("R1 load after", 64'(load), 0);
    chk("R1 window word0", 64'(window), 64'(sw(0)));
    chk("R1 addr after", 64'(ram_addr), 2);

    // directed corner cases
    step(1, 2'd0, 6'd5, 6'd9, 6'd1, 6'd2, "R5 sel0 R3");
    step(1, 2'd1, 6'd5, 6'd9, 6'd1, 6'd2, "R5 sel1");
    step(1, 2'd2, 6'd5, 6'd9, 6'd1, 6'd2, "R5 sel2");
    step(1, 2'd3, 6'd5, 6'd9, 6'd13, 6'd2, "R5 sel3");
    step(1, 2'd0, 6'd0, 6'd30, 6'd30, 6'd30, "R6 zero");
    step(0, 2'd1, 6'd0, 6'd30, 6'd30, 6'd30, "R7 idle");
    step(0, 2'd2, 6'd31, 6'd31, 6'd31, 6'd31, "R7 idle2");
    step(1, 2'd2, 6'd0, 6'd0, 6'd32 - 6'(consumed % 32), 6'd0, "R4 exact word end");
    step(1, 2'd0, 6'd31, 6'd0, 6'd0, 6'd0, "R3 to pos31");
    step(1, 2'd1, 6'd0, 6'd2, 6'd0, 6'd0, "R4 cross from 31");
    step(1, 2'd3, 6'd0, 6'd0, 6'd0, 6'd32, "R4 full word");
    step(1, 2'd1, 6'd0, 6'd40, 6'd0, 6'd0, "R8 clamp40");
    step(1, 2'd0, 6'd63, 6'd0, 6'd0, 6'd0, "R8 clamp63");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic a;
      logic [5:0] r0, r1, r2, r3;
      a  = ($urandom % 5) != 0;
      r0 = 6'($urandom % 34); r1 = 6'($urandom % 34);
      r2 = 6'($urandom % 34); r3 = 6'(($urandom % 8 == 0) ? $urandom % 64 : $urandom % 20);
      step(a, 2'($urandom % 4), r0, r1, r2, r3, "rand R3");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule